// File: doc/BRIEF.md
# Multi-Mode Serial Transmitter with Line Break

The block serializes words for an asynchronous serial line. A word enters through a one-entry holding register over a valid/ready handshake. The engine copies it into a shift register at a bit boundary and shifts it out least significant bit first. A bit boundary is a cycle in which the external `bit_tick` enable is high, so one bit time lasts from one tick to the next.

Static configuration pins control the frame:
- the frame layout, chosen by a 3-bit mode code;
- parity enable and parity sense;
- the transmit enable;
- the interrupt enable.

A software-written ninth-bit flag (`tb8_q`) supplies the extra bit in two of the modes, and it clears itself when each frame ends. Separately from data, a break request drives the line low for a short or a long interval. The length of that interval follows the current frame length M, which counts the start bit, data bits, any extra bit and the stop bit.

Back-pressure works as follows. `in_ready` is high only while the holding register is empty. A word is accepted on a clock edge where both `in_valid` and `in_ready` are high. `in_data` must stay stable while `in_valid` is high and `in_ready` is low. The holding register is released at the bit boundary where the engine takes it. A word that is already waiting when a frame ends starts at that same boundary, with no idle bit in between.

Top module: `ser_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` and `hold_empty` are 1, `tx_irq` is 0 and `tb8_q` is 0.
- R2: A word is accepted when `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0, and it stays 0 until the engine takes the word at a bit boundary. A waiting word starts at the same boundary that ends the previous stop bit, so frames follow each other with no gap.
- R3: The line idles at 1 and changes only in the cycle after a `bit_tick`. Each frame is one start bit (0), then the data bits LSB first, then the extra bit if the mode has one, then one stop bit (1). Mode code 001 sends 7 data bits (`in_data[6:0]`) followed by a parity bit only when `cfg_par_en` is 1, so M is 10 or 9.
- R4: Mode code 010 sends 8 data bits followed by `tb8_q` as the ninth bit and never a parity bit (M = 11).
- R5: Mode code 011 sends 8 data bits followed by one extra bit. The extra bit is the parity bit when `cfg_par_en` is 1 and `tb8_q` otherwise (M = 11).
- R6: Mode code 100 sends 7 data bits, never a parity bit, and `in_data[7]` is not sent (M = 9).
- R7: `tb8_wr` loads `tb8_wdata` into `tb8_q`. A frame uses the `tb8_q` value it was loaded with. `tb8_q` returns to 0 at the end of every frame's stop bit, unless it is written in that same cycle.
- R8: With parity enabled, `cfg_par_even`=1 makes the number of ones across the data bits and the parity bit even. `cfg_par_even`=0 makes that number odd.
- R9: A `brk_req` pulse with `brk_long`=0, made while the engine is idle, drives `txd` low for exactly M+1 bit times starting at the next boundary. `txd` is then high for exactly one bit time before a waiting word starts. A pending break takes priority over a waiting word.
- R10: With `brk_long`=1, the low interval is exactly 2M+4 bit times. The same single high guard bit follows it.
- R11: `tx_irq` is 1 exactly when the holding register is empty and `cfg_tx_ie` is 1.
- R12: While `cfg_tx_en` is 0, or the mode code is one of the unused values 000, 101, 110 or 111, no frame and no break starts and the line stays high. Words are still accepted into the holding register and are sent once transmission is allowed again.
- R13: A `brk_req` made while a frame is being sent is ignored. Only that frame appears on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| cfg_mode | input | 3 | Frame layout code (001, 010, 011, 100 valid) |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even total ones, 0 = odd |
| cfg_tx_en | input | 1 | Allows new frames and breaks to start |
| cfg_tx_ie | input | 1 | Interrupt enable for empty holding register |
| tb8_wr | input | 1 | Write strobe for the ninth-bit flag |
| tb8_wdata | input | 1 | Value written to the ninth-bit flag |
| tb8_q | output | 1 | Current ninth-bit flag |
| brk_req | input | 1 | Break request pulse |
| brk_long | input | 1 | Selects the long break length |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Holding register can accept a word |
| in_data | input | 8 | Word to send |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register is empty |
| tx_irq | output | 1 | Transmit-ready interrupt |

## Verification
The hardest situation to create from the ports is the hand-off between a break and a word that is waiting. This case shows the break's priority, its exact low length and the single guard bit. To reach it, the bench requests a break while the engine is idle and fills the holding register in the very next cycle, before the first boundary arrives. Back-to-back frames are reached the same way: a word is offered as soon as `in_ready` rises during the preceding frame, so a word is always waiting when the stop bit ends. A reference model that advances every clock checks the line, the handshake, the interrupt and the flag throughout these sequences.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRM_MAX = 11;
  localparam int FLEN_W  = $clog2(FRM_MAX + 1);
  localparam int CNT_W   = $clog2(2 * FRM_MAX + 4);

  localparam logic [2:0] MD_SEVEN_P = 3'b001;
  localparam logic [2:0] MD_NINE_T  = 3'b010;
  localparam logic [2:0] MD_EIGHT_X = 3'b011;
  localparam logic [2:0] MD_SEVEN_N = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_BRK   = 2'd2,
    ST_GUARD = 2'd3
  } eng_st_t;
endpackage

// File: rtl/txr_frame_fmt.sv
module txr_frame_fmt
  import ser_tx_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              tb8,
  input  logic [DATA_W-1:0] data,
  output logic [FRM_MAX-1:0] frame,
  output logic [FLEN_W-1:0] flen,
  output logic              mode_ok
);
  logic        par7, par8, ext_on, ext_bit;
  int unsigned nd;

  // Parity covers only the data bits that are actually sent
  assign par7 = par_even ? ^data[6:0] : ~^data[6:0];
  assign par8 = par_even ? ^data      : ~^data;

  always_comb begin
    mode_ok = 1'b1;
    nd      = 8;
    ext_on  = 1'b0;
    ext_bit = 1'b0;
    case (mode)
      MD_SEVEN_P: begin nd = 7; ext_on = par_en; ext_bit = par7; end
      MD_NINE_T:  begin ext_on = 1'b1; ext_bit = tb8; end
      MD_EIGHT_X: begin ext_on = 1'b1; ext_bit = par_en ? par8 : tb8; end
      MD_SEVEN_N: begin nd = 7; end
      default:    mode_ok = 1'b0;
    endcase
    // Fill with ones so the stop bit lands right after the last payload bit
    frame    = '1;
    frame[0] = 1'b0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      if (i < nd) frame[1 + i] = data[i];
    end
    if (ext_on) frame[1 + nd] = ext_bit;
    flen = FLEN_W'(nd + 2 + (ext_on ? 1 : 0));
  end
endmodule

// File: rtl/txr_hold.sv
module txr_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         in_ready,
  output logic         full,
  output logic [W-1:0] q
);
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      q    <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import ser_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               frame_ok,
  input  logic               hold_full,
  input  logic [FRM_MAX-1:0] frame,
  input  logic [FLEN_W-1:0]  flen,
  input  logic               brk_req,
  input  logic               brk_long,
  output logic               txd,
  output logic               take,
  output logic               frame_end,
  output eng_st_t            st
);
  logic [CNT_W-1:0]   cnt, brk_n;
  logic [FRM_MAX-2:0] sh;
  logic               brk_pend, brk_lng;
  logic               bnd, start_brk, start_frm;

  assign frame_end = tick && (st == ST_SEND) && (cnt == '0);
  assign bnd       = tick && ((st == ST_IDLE) || (st == ST_GUARD) || frame_end);
  assign start_brk = bnd && brk_pend && frame_ok;
  assign start_frm = bnd && !brk_pend && frame_ok && hold_full;
  assign take      = start_frm;
  // Counter holds remaining bit times minus one
  assign brk_n     = brk_lng ? (CNT_W'({flen, 1'b0}) + CNT_W'(3)) : CNT_W'(flen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_pend <= 1'b0;
      brk_lng  <= 1'b0;
    end else if (brk_req && (st == ST_IDLE) && !brk_pend && frame_ok && !start_frm) begin
      brk_pend <= 1'b1;
      brk_lng  <= brk_long;
    end else if (bnd && brk_pend) begin
      brk_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      sh  <= '1;
      txd <= 1'b1;
    end else if (start_brk) begin
      st  <= ST_BRK;
      txd <= 1'b0;
      cnt <= brk_n;
    end else if (start_frm) begin
      st  <= ST_SEND;
      txd <= frame[0];
      sh  <= frame[FRM_MAX-1:1];
      cnt <= CNT_W'(flen) - CNT_W'(1);
    end else if (bnd) begin
      st  <= ST_IDLE;
      txd <= 1'b1;
    end else if (tick) begin
      case (st)
        ST_SEND: begin
          txd <= sh[0];
          sh  <= {1'b1, sh[FRM_MAX-2:1]};
          cnt <= cnt - CNT_W'(1);
        end
        ST_BRK: begin
          if (cnt == '0) begin
            st  <= ST_GUARD;
            txd <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ser_tx_brk.sv
module ser_tx_brk
  import ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_tx_en,
  input  logic              cfg_tx_ie,
  input  logic              tb8_wr,
  input  logic              tb8_wdata,
  output logic              tb8_q,
  input  logic              brk_req,
  input  logic              brk_long,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_irq
);
  logic               hold_full, take, frame_end, mode_ok, frame_ok, tb8_nxt;
  logic [DATA_W-1:0]  hold_q;
  logic [FRM_MAX-1:0] frame;
  logic [FLEN_W-1:0]  flen;
  eng_st_t            eng_st;
  logic               eng_idle, eng_brk;

  assign frame_ok   = cfg_tx_en && mode_ok;
  assign hold_empty = !hold_full;
  assign tx_irq     = hold_empty && cfg_tx_ie;
  assign eng_idle   = (eng_st == ST_IDLE);
  assign eng_brk    = (eng_st == ST_BRK);

  // Next flag value feeds the formatter so a frame loaded at the end of the
  // previous one sees the cleared flag
  assign tb8_nxt = tb8_wr ? tb8_wdata : (frame_end ? 1'b0 : tb8_q);

  always_ff @(posedge clk) begin
    if (!rst_n) tb8_q <= 1'b0;
    else        tb8_q <= tb8_nxt;
  end

  txr_hold #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(take), .in_ready(in_ready), .full(hold_full), .q(hold_q)
  );

  txr_frame_fmt u_fmt (
    .mode(cfg_mode), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .tb8(tb8_nxt), .data(hold_q), .frame(frame), .flen(flen), .mode_ok(mode_ok)
  );

  txr_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .frame_ok(frame_ok),
    .hold_full(hold_full), .frame(frame), .flen(flen), .brk_req(brk_req),
    .brk_long(brk_long), .txd(txd), .take(take), .frame_end(frame_end), .st(eng_st)
  );
endmodule

// File: rtl/ser_tx_brk_chk.sv
module ser_tx_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic txd,
  input logic in_valid,
  input logic in_ready,
  input logic tx_irq,
  input logic frame_ok,
  input logic eng_idle,
  input logic eng_brk,
  input logic frame_end,
  input logic tb8_wr,
  input logic tb8_q
);
  // R2: an accepted word blocks further input in the following cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3: the line only moves after a bit boundary
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));

  // R7: the flag is gone after a frame ends unless rewritten
  p_tb8_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !tb8_wr) |=> !tb8_q);

  // R9: the line is low throughout a break
  p_brk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_brk |-> !txd);

  // R11: a filled holding register silences the interrupt
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !tx_irq);

  // R12: nothing starts while transmission is not allowed
  p_no_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_idle && !frame_ok) |=> txd);
endmodule

bind ser_tx_brk ser_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .txd(txd),
  .in_valid(in_valid), .in_ready(in_ready), .tx_irq(tx_irq),
  .frame_ok(frame_ok), .eng_idle(eng_idle), .eng_brk(eng_brk),
  .frame_end(frame_end), .tb8_wr(tb8_wr), .tb8_q(tb8_q)
);

// File: tb/tb_ser_tx_brk.sv
`timescale 1ns/1ps
module tb_ser_tx_brk;
  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic [2:0] cfg_mode = 3'b001;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_tx_en = 1'b1, cfg_tx_ie = 1'b0;
  logic tb8_wr = 1'b0, tb8_wdata = 1'b0, tb8_q;
  logic brk_req = 1'b0, brk_long = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic txd, hold_empty, tx_irq;

  int checks = 0, fails = 0, divc = 0;
  bit line_q[$];

  always #4 clk = ~clk;

  ser_tx_brk dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_mode(cfg_mode),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_tx_en(cfg_tx_en),
    .cfg_tx_ie(cfg_tx_ie), .tb8_wr(tb8_wr), .tb8_wdata(tb8_wdata), .tb8_q(tb8_q),
    .brk_req(brk_req), .brk_long(brk_long), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .txd(txd), .hold_empty(hold_empty), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected frame from the requirements: returns M, bits LSB first in v
  function automatic int build(input logic [2:0] md, input bit pe, input bit ev,
                               input bit t8, input logic [7:0] d, output logic [15:0] v);
    int nd, n; bit p;
    nd = (md == 3'd1 || md == 3'd4) ? 7 : 8;
    p = 1'b0;
    for (int i = 0; i < nd; i++) p ^= d[i];
    if (!ev) p = ~p;
    v = '1; v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[1 + i] = d[i];
    n = 1 + nd;
    if (md == 3'd1 && pe) begin v[n] = p; n++; end
    if (md == 3'd2) begin v[n] = t8; n++; end
    if (md == 3'd3) begin v[n] = pe ? p : t8; n++; end
    return n + 1;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin divc = 0; bit_tick = 1'b0; end
    else begin bit_tick = (divc == 3); divc = (divc + 1) % 4; end
  end

  always @(posedge clk) begin
    if (rst_n && bit_tick) begin #2 line_q.push_back(txd); end
  end

  // Reference model, advanced on every clock
  int m_st, m_cnt; bit m_q[$]; bit m_txd, m_hf, m_tb8, m_bp, m_bl; logic [7:0] m_hd;
  always @(posedge clk) begin : mdl
    bit ok, fend, bnd, t8n, sb, sf, acc, bacc; logic [15:0] v; int n;
    if (!rst_n) begin
      m_st = 0; m_q.delete(); m_cnt = 0; m_txd = 1; m_hf = 0; m_hd = 0;
      m_tb8 = 0; m_bp = 0; m_bl = 0;
    end else begin
      ok   = cfg_tx_en && cfg_mode >= 3'd1 && cfg_mode <= 3'd4;
      fend = bit_tick && m_st == 1 && m_q.size() == 0;
      bnd  = bit_tick && (m_st == 0 || m_st == 3 || fend);
      t8n  = tb8_wr ? tb8_wdata : (fend ? 1'b0 : m_tb8);
      sb   = bnd && m_bp && ok;
      sf   = bnd && !m_bp && ok && m_hf;
      acc  = in_valid && !m_hf;
      bacc = brk_req && m_st == 0 && !m_bp && ok && !sf;
      if (sb) begin
        n = build(cfg_mode, cfg_par_en, cfg_par_even, 1'b0, 8'h00, v);
        m_st = 2; m_txd = 0; m_cnt = (m_bl ? 2 * n + 4 : n + 1) - 1;
      end else if (sf) begin
        n = build(cfg_mode, cfg_par_en, cfg_par_even, t8n, m_hd, v);
        m_st = 1; m_txd = 0; m_q.delete();
        for (int i = 1; i < n; i++) m_q.push_back(v[i]);
      end else if (bnd) begin
        m_st = 0; m_txd = 1;
      end else if (bit_tick && m_st == 1) begin
        m_txd = m_q.pop_front();
      end else if (bit_tick && m_st == 2) begin
        if (m_cnt == 0) begin m_st = 3; m_txd = 1; end else m_cnt--;
      end
      if (acc) begin m_hf = 1; m_hd = in_data; end else if (sf) m_hf = 0;
      m_tb8 = t8n;
      if (bacc) begin m_bp = 1; m_bl = brk_long; end else if (bnd && m_bp) m_bp = 0;
      #2;
      chk(txd === m_txd, "R3 line vs model", txd, m_txd);
      chk(in_ready === !m_hf, "R2 in_ready vs model", in_ready, !m_hf);
      chk(tx_irq === (!m_hf && cfg_tx_ie), "R11 tx_irq vs model", tx_irq, !m_hf && cfg_tx_ie);
      chk(tb8_q === m_tb8, "R7 tb8_q vs model", tb8_q, m_tb8);
    end
  end

  task automatic send_word(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pulse_brk(input bit lng);
    @(negedge clk); brk_req = 1'b1; brk_long = lng;
    @(negedge clk); brk_req = 1'b0;
  endtask

  task automatic set_tb8(input bit val);
    @(negedge clk); tb8_wr = 1'b1; tb8_wdata = val;
    @(negedge clk); tb8_wr = 1'b0;
  endtask

  task automatic chk_frame(input string tag, input logic [15:0] v, input int n,
                           input bit strict, inout int pos);
    int s, bad;
    s = pos;
    if (!strict) while (s < line_q.size() && line_q[s] != 1'b0) s++;
    bad = 0;
    for (int i = 0; i < n; i++)
      if (s + i >= line_q.size() || line_q[s + i] !== v[i]) bad++;
    chk(bad == 0, tag, bad, 0);
    pos = s + n;
  endtask

  task automatic chk_low(input string tag, input int len, inout int pos);
    int s, e;
    s = pos;
    while (s < line_q.size() && line_q[s] != 1'b0) s++;
    e = s;
    while (e < line_q.size() && line_q[e] == 1'b0) e++;
    chk(e - s == len && e < line_q.size(), tag, e - s, len);
    pos = e;
  endtask

  function automatic int zeros_from(input int pos);
    int z = 0;
    for (int i = pos; i < line_q.size(); i++) if (line_q[i] == 1'b0) z++;
    return z;
  endfunction

  task automatic one_frame(input string tag, input logic [2:0] md, input bit pe,
                           input bit ev, input logic [7:0] d);
    logic [15:0] v; int n, pos;
    cfg_mode = md; cfg_par_en = pe; cfg_par_even = ev;
    line_q.delete(); pos = 0;
    n = build(md, pe, ev, tb8_q, d, v);
    send_word(d);
    wait_bits(15);
    chk_frame(tag, v, n, 1'b0, pos);
  endtask

  initial begin
    logic [15:0] v; int n, pos;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b1 && hold_empty === 1'b1, "R1 reset line/ready", txd, 1);
    chk(tx_irq === 1'b0 && tb8_q === 1'b0, "R1 reset irq/tb8", tx_irq, 0);
    rst_n = 1'b1;
    wait_bits(2);

    one_frame("R3 mode 001 parity even", 3'd1, 1'b1, 1'b1, 8'h35);
    one_frame("R8 mode 001 parity odd", 3'd1, 1'b1, 1'b0, 8'h35);
    one_frame("R3 mode 001 no parity", 3'd1, 1'b0, 1'b0, 8'h6B);

    set_tb8(1'b1);
    one_frame("R4 mode 010 ninth bit set", 3'd2, 1'b0, 1'b0, 8'hA5);
    chk(tb8_q === 1'b0, "R7 flag cleared after frame", tb8_q, 0);
    one_frame("R7 mode 010 ninth bit after clear", 3'd2, 1'b0, 1'b0, 8'hA5);

    one_frame("R5 mode 011 parity even", 3'd3, 1'b1, 1'b1, 8'hFF);
    one_frame("R8 mode 011 parity odd", 3'd3, 1'b1, 1'b0, 8'h01);
    set_tb8(1'b1);
    one_frame("R5 mode 011 flag as extra bit", 3'd3, 1'b0, 1'b0, 8'h0F);
    one_frame("R6 mode 100 seven bits", 3'd4, 1'b1, 1'b1, 8'h80);

    // R2: back-to-back words
    cfg_mode = 3'd4; line_q.delete(); pos = 0;
    send_word(8'h11);
    chk(in_ready === 1'b0, "R2 ready low after accept", in_ready, 0);
    send_word(8'h22);
    send_word(8'h33);
    wait_bits(35);
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h11, v); chk_frame("R2 first frame", v, n, 1'b0, pos);
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h22, v); chk_frame("R2 second frame no gap", v, n, 1'b1, pos);
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h33, v); chk_frame("R2 third frame no gap", v, n, 1'b1, pos);

    // R9: short break beats a waiting word, then one guard bit
    cfg_mode = 3'd4; line_q.delete(); pos = 0;
    pulse_brk(1'b0);
    send_word(8'h3C);
    wait_bits(28);
    chk_low("R9 short break length", 10, pos);
    pos = pos + 1;
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h3C, v); chk_frame("R9 word after one guard bit", v, n, 1'b1, pos);

    // R10: long break in mode 001 with parity (M = 10)
    cfg_mode = 3'd1; cfg_par_en = 1'b1; line_q.delete(); pos = 0;
    pulse_brk(1'b1);
    wait_bits(32);
    chk_low("R10 long break length", 24, pos);
    chk(zeros_from(pos) == 0, "R10 line high after break", zeros_from(pos), 0);

    // R13: break request during a frame is ignored
    cfg_mode = 3'd4; cfg_par_en = 1'b0; line_q.delete(); pos = 0;
    send_word(8'h5A);
    wait_bits(3);
    pulse_brk(1'b0);
    wait_bits(20);
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h5A, v); chk_frame("R13 frame intact", v, n, 1'b0, pos);
    chk(zeros_from(pos) == 0, "R13 no break after frame", zeros_from(pos), 0);

    // R11 / R12: interrupt and disabled transmission
    cfg_tx_ie = 1'b1;
    @(negedge clk);
    chk(tx_irq === 1'b1, "R11 irq when empty and enabled", tx_irq, 1);
    cfg_tx_en = 1'b0; line_q.delete();
    send_word(8'h77);
    chk(tx_irq === 1'b0, "R11 irq low when holding full", tx_irq, 0);
    pulse_brk(1'b0);
    wait_bits(15);
    chk(zeros_from(0) == 0 && in_ready === 1'b0, "R12 disabled: no frame or break", zeros_from(0), 0);
    cfg_mode = 3'b110; cfg_tx_en = 1'b1; line_q.delete();
    wait_bits(15);
    chk(zeros_from(0) == 0 && in_ready === 1'b0, "R12 reserved mode: no frame", zeros_from(0), 0);
    cfg_mode = 3'd4; line_q.delete(); pos = 0;
    wait_bits(14);
    n = build(3'd4, 1'b0, 1'b0, 1'b0, 8'h77, v); chk_frame("R12 held word sent when allowed", v, n, 1'b0, pos);
    chk(tx_irq === 1'b1, "R11 irq back after send", tx_irq, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule